// File: doc/BRIEF.md
# Per-Lane Transmit Drive Code Selector

This block produces the transmit voltage code and the de-emphasis code for every SerDes lane of a multi-port switch. Each four-lane quad keeps two small settings registers per lane. Software writes them through one write port that names a quad and then either one lane or all four lanes of that quad. A second write port fills a 3-bit transmit margin field for each port. A per-quad width setting decides which port owns each lane.

On every clock, each lane looks up the margin field of its owning port. A field of zero means the normal operating range. In that case the lane drives the voltage held in its own registers. Any other value is driven unchanged on every lane of that port, and the per-lane voltage is set aside. The de-emphasis code always comes from the lane's own registers. It is formed from a nominal level plus signed coarse and fine steps, then clamped to the legal range.

Port numbering is fixed. Quads in the lower half (quads 0..3 by default) own two port numbers each, starting at 2*q. Quads in the upper half own four port numbers each, starting at 2*LOW_QUADS + 4*(q-LOW_QUADS). With the defaults this gives 24 ports, and quad 6 starts at port 16.

Top module: `tx_margin_sel`

## Requirements
- R1: When the owning port's margin field is 3'b000, a lane's tx_volt equals the 3-bit voltage in that lane's register 0 (write data bits [2:0] with lw_sel=0).
- R2: When the owning port's margin field is nonzero, every lane of that port drives that field value on tx_volt. Writes to those lanes' voltage registers have no visible effect until the field returns to zero.
- R3: Width mode 2'b00 (x4) gives all four lanes of quad q to the quad's base port. Mode 2'b01 (x2) gives lanes 0,1 to the base port and lanes 2,3 to base+1. For example, quad 0 in x4 is port 0, and quad 2 in x2 gives lanes 0,1 to port 4 and lanes 2,3 to port 5.
- R4: A write with lw_all=0 updates only lane lw_lane of quad lw_quad. Every other lane keeps its settings.
- R5: A write with lw_all=1 updates all four lanes of quad lw_quad on the same clock edge. Lanes of other quads are unchanged.
- R6: Mode 2'b11 (x8) on a quad gives its lanes to the base port of the even quad of its pair. With quads 6 and 7 both in x8, port 16 owns lanes 24..31, and the margin field of port 20 has no effect on them.
- R7: The de-emphasis code is nominal + 4*coarse + fine, clamped to 0..23. Nominal select (register 0, bits [4:3]) maps 0 to 10 (-3.5 dB), 1 to 18 (-6 dB), 2 to 0 (low swing) and 3 to 10. Coarse is signed bits [5:3] and fine is signed bits [2:0] of register 1 (lw_sel=1).
- R8: After reset, every lane drives tx_volt 0 and tx_deemph 10, and every margin field reads as normal range.
- R9: Mode 2'b10 (x1) on an upper-half quad gives lane l to port base+l. On a lower-half quad it behaves like x2.
- R10: A register or margin write sampled at clock edge k appears on the outputs after edge k+1, and not after edge k.
- R11: A margin write whose port index is 24 or above changes no lane's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_mode | input | 2*NUM_QUADS | Width mode per quad: 00 x4, 01 x2, 10 x1, 11 x8 pair |
| lw_en | input | 1 | Lane register write strobe |
| lw_quad | input | 3 | Target quad |
| lw_lane | input | 2 | Target lane when lw_all is 0 |
| lw_all | input | 1 | Write all four lanes of the quad |
| lw_sel | input | 1 | 0: register 0 (nominal, voltage); 1: register 1 (coarse, fine) |
| lw_data | input | 6 | Register write data |
| mg_en | input | 1 | Margin field write strobe |
| mg_port | input | 5 | Target port |
| mg_code | input | 3 | Margin value, 000 is normal range |
| tx_volt | output | 3*NUM_LANES | Final voltage code, lane i at [3i+2:3i] |
| tx_deemph | output | 5*NUM_LANES | De-emphasis code, lane i at [5i+4:5i] |

## Verification
A table walks the de-emphasis arithmetic through all four nominal selects with positive, negative and mixed steps. It includes results that land exactly on the top limit and results that clamp at each end, so a wrong step weight or a missing clamp shows up.

Directed sequences then switch margin fields on and off under each width mode. They check lanes on both sides of each port boundary, which separates a correct owner map from one that is off by one lane or one quad. Other sequences target specific faults:
- Single-lane and broadcast writes are followed by checks on the neighbouring lanes, to catch steering that spills into other lanes.
- An override is applied while the per-lane register changes underneath, to show which source wins.
- An x8 pair gets a stray field on its odd quad's own port number.
- A margin write goes to an out-of-range port index.
- One write is sampled one edge early, to pin the output latency.

// File: rtl/tx_margin_pkg.sv
package tx_margin_pkg;

  localparam int VOLT_W      = 3;
  localparam int DE_W        = 5;
  localparam int DE_MAX      = 23;
  localparam int COARSE_STEP = 4;
  localparam int WDATA_W     = 6;

  typedef enum logic [1:0] {
    MODE_X4 = 2'b00,
    MODE_X2 = 2'b01,
    MODE_X1 = 2'b10,
    MODE_X8 = 2'b11
  } quad_mode_e;

  typedef struct packed {
    logic [1:0]        nom;
    logic [VOLT_W-1:0] volt;
    logic signed [2:0] coarse;
    logic signed [2:0] fine;
  } lane_cfg_t;

  localparam lane_cfg_t LANE_CFG_RST = '{nom: 2'b00, volt: '0, coarse: '0, fine: '0};

  function automatic int nominal_code(input logic [1:0] nom);
    case (nom)
      2'd1:    return 18;
      2'd2:    return 0;
      default: return 10;
    endcase
  endfunction

  function automatic logic [DE_W-1:0] deemph_calc(input lane_cfg_t c);
    int sum;
    sum = nominal_code(c.nom) + COARSE_STEP * int'(c.coarse) + int'(c.fine);
    if (sum < 0)       sum = 0;
    if (sum > DE_MAX)  sum = DE_MAX;
    return DE_W'(sum);
  endfunction

endpackage

// File: rtl/lane_cfg_bank.sv
module lane_cfg_bank
  import tx_margin_pkg::*;
#(
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [LANE_W-1:0]  wr_lane,
  input  logic               wr_all,
  input  logic               wr_sel,
  input  logic [WDATA_W-1:0] wr_data,
  output lane_cfg_t          cfg_o [LANES],
  output logic [LANES-1:0]   lane_we_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we_o[l] = wr_hit && (wr_all || (wr_lane == LANE_W'(l)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_o[l] <= LANE_CFG_RST;
      end else if (lane_we_o[l]) begin
        if (!wr_sel) begin
          cfg_o[l].nom  <= wr_data[4:3];
          cfg_o[l].volt <= wr_data[2:0];
        end else begin
          cfg_o[l].coarse <= wr_data[5:3];
          cfg_o[l].fine   <= wr_data[2:0];
        end
      end
    end
  end

endmodule

// File: rtl/margin_bank.sv
module margin_bank
  import tx_margin_pkg::*;
#(
  parameter int NUM_PORTS = 24,
  localparam int PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mg_en,
  input  logic [PORT_W-1:0] mg_port,
  input  logic [VOLT_W-1:0] mg_code,
  output logic [VOLT_W-1:0] margin_o [NUM_PORTS]
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = mg_en && (mg_port == PORT_W'(p));
    always_ff @(posedge clk) begin
      if (!rst_n)   margin_o[p] <= '0;
      else if (hit) margin_o[p] <= mg_code;
    end
  end

endmodule

// File: rtl/lane_owner_map.sv
module lane_owner_map
  import tx_margin_pkg::*;
#(
  parameter int NUM_QUADS = 8,
  parameter int LOW_QUADS = 4,
  parameter int LANES     = 4,
  parameter int PORT_W    = 5,
  localparam int NUM_LANES = NUM_QUADS * LANES
) (
  input  logic [2*NUM_QUADS-1:0] quad_mode_i,
  output logic [PORT_W-1:0]      owner_o [NUM_LANES]
);

  function automatic int quad_base(input int q);
    if (q < LOW_QUADS) return 2 * q;
    return 2 * LOW_QUADS + 4 * (q - LOW_QUADS);
  endfunction

  function automatic int lane_port(input int q, input int l, input quad_mode_e m);
    case (m)
      MODE_X4: return quad_base(q);
      MODE_X2: return quad_base(q) + l / 2;
      MODE_X1: return (q < LOW_QUADS) ? quad_base(q) + l / 2 : quad_base(q) + l;
      default: return quad_base(q - (q % 2));
    endcase
  endfunction

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    quad_mode_e mode;
    assign mode = quad_mode_e'(quad_mode_i[2*q +: 2]);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign owner_o[q*LANES + l] = PORT_W'(lane_port(q, l, mode));
    end
  end

endmodule

// File: rtl/lane_driver.sv
module lane_driver
  import tx_margin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lane_cfg_t         cfg_i,
  input  logic [VOLT_W-1:0] margin_i,
  output logic              override_o,
  output logic [VOLT_W-1:0] volt_q,
  output logic [DE_W-1:0]   deemph_q
);

  logic [VOLT_W-1:0] volt_d;

  assign override_o = (margin_i != '0);
  assign volt_d     = override_o ? margin_i : cfg_i.volt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      volt_q   <= '0;
      deemph_q <= DE_W'(nominal_code(2'b00));
    end else begin
      volt_q   <= volt_d;
      deemph_q <= deemph_calc(cfg_i);
    end
  end

endmodule

// File: rtl/tx_margin_sel.sv
module tx_margin_sel
  import tx_margin_pkg::*;
#(
  parameter int NUM_QUADS = 8,
  parameter int LOW_QUADS = 4,
  localparam int LANES     = 4,
  localparam int NUM_LANES = NUM_QUADS * LANES,
  localparam int NUM_PORTS = 2 * LOW_QUADS + 4 * (NUM_QUADS - LOW_QUADS),
  localparam int QUAD_W    = $clog2(NUM_QUADS),
  localparam int LANE_W    = $clog2(LANES),
  localparam int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*NUM_QUADS-1:0]      quad_mode,
  input  logic                        lw_en,
  input  logic [QUAD_W-1:0]           lw_quad,
  input  logic [LANE_W-1:0]           lw_lane,
  input  logic                        lw_all,
  input  logic                        lw_sel,
  input  logic [WDATA_W-1:0]          lw_data,
  input  logic                        mg_en,
  input  logic [PORT_W-1:0]           mg_port,
  input  logic [VOLT_W-1:0]           mg_code,
  output logic [VOLT_W*NUM_LANES-1:0] tx_volt,
  output logic [DE_W*NUM_LANES-1:0]   tx_deemph
);

  lane_cfg_t         lane_cfg     [NUM_LANES];
  logic [VOLT_W-1:0] margin       [NUM_PORTS];
  logic [PORT_W-1:0] owner        [NUM_LANES];
  logic [VOLT_W-1:0] owner_margin [NUM_LANES];

  // Observation wires for the bound checker
  logic [NUM_LANES-1:0]        dbg_lane_we;
  logic [NUM_LANES-1:0]        dbg_override;
  logic [PORT_W*NUM_LANES-1:0] dbg_owner;
  logic [VOLT_W*NUM_LANES-1:0] dbg_owner_margin;
  logic [VOLT_W*NUM_LANES-1:0] dbg_reg_volt;

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    lane_cfg_t quad_cfg [LANES];
    logic      hit;
    assign hit = lw_en && (lw_quad == QUAD_W'(q));

    lane_cfg_bank #(.LANES(LANES)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit),
      .wr_lane   (lw_lane),
      .wr_all    (lw_all),
      .wr_sel    (lw_sel),
      .wr_data   (lw_data),
      .cfg_o     (quad_cfg),
      .lane_we_o (dbg_lane_we[q*LANES +: LANES])
    );

    for (genvar l = 0; l < LANES; l++) begin : g_flat
      assign lane_cfg[q*LANES + l] = quad_cfg[l];
    end
  end

  margin_bank #(.NUM_PORTS(NUM_PORTS)) margin_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mg_en    (mg_en),
    .mg_port  (mg_port),
    .mg_code  (mg_code),
    .margin_o (margin)
  );

  lane_owner_map #(
    .NUM_QUADS (NUM_QUADS),
    .LOW_QUADS (LOW_QUADS),
    .LANES     (LANES),
    .PORT_W    (PORT_W)
  ) map_i (
    .quad_mode_i (quad_mode),
    .owner_o     (owner)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_drv
    assign owner_margin[i] = margin[owner[i]];

    lane_driver drv_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_i      (lane_cfg[i]),
      .margin_i   (owner_margin[i]),
      .override_o (dbg_override[i]),
      .volt_q     (tx_volt[VOLT_W*i +: VOLT_W]),
      .deemph_q   (tx_deemph[DE_W*i +: DE_W])
    );

    assign dbg_owner[PORT_W*i +: PORT_W]        = owner[i];
    assign dbg_owner_margin[VOLT_W*i +: VOLT_W] = owner_margin[i];
    assign dbg_reg_volt[VOLT_W*i +: VOLT_W]     = lane_cfg[i].volt;
  end

endmodule

// File: rtl/tx_margin_chk.sv
module tx_margin_chk
  import tx_margin_pkg::*;
#(
  parameter int NUM_QUADS = 8,
  parameter int LOW_QUADS = 4,
  localparam int LANES     = 4,
  localparam int NUM_LANES = NUM_QUADS * LANES,
  localparam int NUM_PORTS = 2 * LOW_QUADS + 4 * (NUM_QUADS - LOW_QUADS),
  localparam int QUAD_W    = $clog2(NUM_QUADS),
  localparam int LANE_W    = $clog2(LANES),
  localparam int PORT_W    = $clog2(NUM_PORTS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2*NUM_QUADS-1:0]      quad_mode,
  input logic                        lw_en,
  input logic [QUAD_W-1:0]           lw_quad,
  input logic [LANE_W-1:0]           lw_lane,
  input logic                        lw_all,
  input logic [VOLT_W*NUM_LANES-1:0] tx_volt,
  input logic [DE_W*NUM_LANES-1:0]   tx_deemph,
  input logic [NUM_LANES-1:0]        dbg_lane_we,
  input logic [PORT_W*NUM_LANES-1:0] dbg_owner,
  input logic [VOLT_W*NUM_LANES-1:0] dbg_owner_margin,
  input logic [VOLT_W*NUM_LANES-1:0] dbg_reg_volt
);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    AST_NORMAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_owner_margin[VOLT_W*i +: VOLT_W] == '0) |=>
      (tx_volt[VOLT_W*i +: VOLT_W] == $past(dbg_reg_volt[VOLT_W*i +: VOLT_W]))); // R1
    AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_owner_margin[VOLT_W*i +: VOLT_W] != '0) |=>
      (tx_volt[VOLT_W*i +: VOLT_W] == $past(dbg_owner_margin[VOLT_W*i +: VOLT_W]))); // R2
    AST_DEEMPH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_deemph[DE_W*i +: DE_W]) <= DE_MAX)); // R7
    AST_OWNER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dbg_owner[PORT_W*i +: PORT_W]) < NUM_PORTS)); // R3
  end

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
    AST_SINGLE_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lw_en && !lw_all && lw_quad == QUAD_W'(q)) |->
      ($countones(dbg_lane_we[q*LANES +: LANES]) == 1 && dbg_lane_we[q*LANES + int'(lw_lane)])); // R4
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!lw_en || lw_quad != QUAD_W'(q)) |-> (dbg_lane_we[q*LANES +: LANES] == '0)); // R4
    AST_BCAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lw_en && lw_all && lw_quad == QUAD_W'(q)) |-> (&dbg_lane_we[q*LANES +: LANES])); // R5
    if (q % 2 == 1) begin : g_pair
      for (genvar l = 0; l < LANES; l++) begin : g_pl
        AST_X8_PAIR_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
          (quad_mode[2*q +: 2] == MODE_X8) |->
          (dbg_owner[PORT_W*(q*LANES + l) +: PORT_W] == dbg_owner[PORT_W*((q-1)*LANES) +: PORT_W])); // R6
      end
    end
  end

endmodule

bind tx_margin_sel tx_margin_chk #(.NUM_QUADS(NUM_QUADS), .LOW_QUADS(LOW_QUADS)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .quad_mode        (quad_mode),
  .lw_en            (lw_en),
  .lw_quad          (lw_quad),
  .lw_lane          (lw_lane),
  .lw_all           (lw_all),
  .tx_volt          (tx_volt),
  .tx_deemph        (tx_deemph),
  .dbg_lane_we      (dbg_lane_we),
  .dbg_owner        (dbg_owner),
  .dbg_owner_margin (dbg_owner_margin),
  .dbg_reg_volt     (dbg_reg_volt)
);

// File: tb/tx_margin_sel_tb.sv
module tx_margin_sel_tb_top;

  localparam int NQ = 8;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2*NQ-1:0] quad_mode;
  logic          lw_en, lw_all, lw_sel;
  logic [2:0]    lw_quad;
  logic [1:0]    lw_lane;
  logic [5:0]    lw_data;
  logic          mg_en;
  logic [4:0]    mg_port;
  logic [2:0]    mg_code;
  logic [3*NL-1:0] tx_volt;
  logic [5*NL-1:0] tx_deemph;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  tx_margin_sel dut_i (
    .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode),
    .lw_en(lw_en), .lw_quad(lw_quad), .lw_lane(lw_lane), .lw_all(lw_all),
    .lw_sel(lw_sel), .lw_data(lw_data),
    .mg_en(mg_en), .mg_port(mg_port), .mg_code(mg_code),
    .tx_volt(tx_volt), .tx_deemph(tx_deemph)
  );

  // nom[1:0], coarse[2:0], fine[2:0], expected de-emphasis code
  localparam logic [12:0] DE_VEC [8] = '{
    {2'd0, 3'sd0,  3'sd0,  5'd10},
    {2'd1, 3'sd3,  3'sd3,  5'd23},
    {2'd2, -3'sd1, 3'sd0,  5'd0},
    {2'd0, 3'sd2,  -3'sd3, 5'd15},
    {2'd1, -3'sd4, -3'sd4, 5'd0},
    {2'd2, 3'sd1,  3'sd2,  5'd6},
    {2'd3, 3'sd0,  -3'sd1, 5'd9},
    {2'd1, 3'sd1,  3'sd1,  5'd23}
  };

  function automatic int volt_of(input int lane);
    return int'(tx_volt[3*lane +: 3]);
  endfunction

  function automatic int de_of(input int lane);
    return int'(tx_deemph[5*lane +: 5]);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic lane_write(input int q, input int l, input bit all, input bit sel, input logic [5:0] d);
    lw_en = 1'b1; lw_quad = 3'(q); lw_lane = 2'(l); lw_all = all; lw_sel = sel; lw_data = d;
    @(negedge clk);
    lw_en = 1'b0; lw_all = 1'b0;
  endtask

  task automatic margin_write(input int p, input int code);
    mg_en = 1'b1; mg_port = 5'(p); mg_code = 3'(code);
    @(negedge clk);
    mg_en = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_mode(input int q, input logic [1:0] m);
    quad_mode[2*q +: 2] = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0; quad_mode = '0;
    lw_en = 0; lw_quad = 0; lw_lane = 0; lw_all = 0; lw_sel = 0; lw_data = 0;
    mg_en = 0; mg_port = 0; mg_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    bad = 0;
    for (int i = 0; i < NL; i++) if (volt_of(i) != 0 || de_of(i) != 10) bad++;
    check("R8", "lanes off reset value", bad, 0);

    // R7: de-emphasis table on quad 1 lane 2 (lane 6)
    for (int v = 0; v < 8; v++) begin
      lane_write(1, 2, 1'b0, 1'b0, {1'b0, DE_VEC[v][12:11], 3'(v)});
      lane_write(1, 2, 1'b0, 1'b1, {DE_VEC[v][10:8], DE_VEC[v][7:5]});
      settle();
      check("R7", $sformatf("deemph vec %0d", v), de_of(6), int'(DE_VEC[v][4:0]));
      check("R1", $sformatf("volt vec %0d", v), volt_of(6), v);
    end

    // R10: latency of a single lane write (quad 0 lane 1)
    lw_en = 1'b1; lw_quad = 3'd0; lw_lane = 2'd1; lw_all = 1'b0; lw_sel = 1'b0; lw_data = 6'd5;
    @(negedge clk);
    lw_en = 1'b0;
    check("R10", "lane1 one edge after write", volt_of(1), 0);
    @(negedge clk);
    check("R10", "lane1 two edges after write", volt_of(1), 5);
    // R4: neighbours untouched
    check("R4", "lane0 after lane1 write", volt_of(0), 0);
    check("R4", "lane5 after lane1 write", volt_of(5), 0);

    // R5: broadcast to quad 3
    lane_write(3, 0, 1'b1, 1'b0, 6'd6);
    settle();
    bad = 0;
    for (int i = 12; i < 16; i++) if (volt_of(i) != 6) bad++;
    check("R5", "quad3 lanes not all updated", bad, 0);
    check("R5", "lane11 untouched", volt_of(11), 0);
    check("R5", "lane16 untouched", volt_of(16), 0);

    // R2/R3: x4 quad 0 override via port 0
    margin_write(0, 3);
    settle();
    bad = 0;
    for (int i = 0; i < 4; i++) if (volt_of(i) != 3) bad++;
    check("R3", "x4 port0 lanes not overridden", bad, 0);
    check("R3", "lane4 not in port0", volt_of(4), 0);
    margin_write(0, 0);
    settle();
    check("R1", "lane1 back to register", volt_of(1), 5);
    check("R1", "lane0 back to register", volt_of(0), 0);

    // R3: x2 on quad 2, ports 4 and 5
    set_mode(2, 2'b01);
    lane_write(2, 0, 1'b1, 1'b0, 6'd2);
    margin_write(4, 7);
    settle();
    check("R3", "x2 lane8 port4", volt_of(8), 7);
    check("R3", "x2 lane9 port4", volt_of(9), 7);
    check("R3", "x2 lane10 keeps register", volt_of(10), 2);
    check("R3", "x2 lane11 keeps register", volt_of(11), 2);
    margin_write(5, 4);
    settle();
    check("R3", "x2 lane10 port5", volt_of(10), 4);
    check("R3", "x2 lane11 port5", volt_of(11), 4);
    check("R3", "x2 lane9 still port4", volt_of(9), 7);

    // R6: x8 across quads 6 and 7
    set_mode(6, 2'b11);
    set_mode(7, 2'b11);
    lane_write(7, 0, 1'b1, 1'b0, 6'd1);
    margin_write(20, 6);
    margin_write(16, 5);
    settle();
    bad = 0;
    for (int i = 24; i < 32; i++) if (volt_of(i) != 5) bad++;
    check("R6", "x8 lanes 24..31 not port16 value", bad, 0);

    // R11: out-of-range margin port index
    margin_write(24, 6);
    margin_write(31, 6);
    settle();
    bad = 0;
    for (int i = 0; i < NL; i++) if (i < 8 || (i >= 12 && i < 24)) if (volt_of(i) == 6 && !(i >= 12 && i < 16)) bad++;
    check("R11", "lanes changed by bad port", bad, 0);
    check("R11", "lane16 after bad port", volt_of(16), 0);

    // R9: x1 on upper quad 4 (ports 8..11)
    set_mode(4, 2'b10);
    margin_write(10, 3);
    settle();
    check("R9", "x1 upper lane18 port10", volt_of(18), 3);
    check("R9", "x1 upper lane17", volt_of(17), 0);
    check("R9", "x1 upper lane19", volt_of(19), 0);
    // R9: x1 on lower quad 1 behaves as x2 (ports 2,3)
    set_mode(1, 2'b10);
    margin_write(3, 2);
    settle();
    check("R9", "x1 lower lane6 port3", volt_of(6), 2);
    check("R9", "x1 lower lane7 port3", volt_of(7), 2);
    check("R9", "x1 lower lane4 port2", volt_of(4), 0);

    // R2: register write hidden by override, visible after clear
    lane_write(1, 3, 1'b0, 1'b0, 6'd1);
    settle();
    check("R2", "lane7 write hidden by override", volt_of(7), 2);
    margin_write(3, 0);
    settle();
    check("R2", "lane7 register after clear", volt_of(7), 1);
    check("R2", "lane6 register after clear", volt_of(6), 7);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule